// File: doc/BRIEF.md
# Asynchronous Static RAM Interface Controller

This block lets a clocked host read and write a 32K x 8 asynchronous static RAM. The host offers one request at a time over a valid/ready handshake. A request carries an address, write data and a direction flag. Read data returns later with a single-cycle valid pulse. On the RAM side the controller drives a 15-bit address bus and active-low chip select, write enable and output enable. It shares one tristate 8-bit data bus with the RAM.

The strobe timing is built from three clock-cycle counts: the read access window, the write pulse and the bus turnaround. Each count is rounded up from the speed-grade time in picoseconds divided by the clock period. The address bus changes only while write enable is high. Write enable falls one cycle after chip select, so the RAM outputs stay high-Z for the whole write. Output enable stays high through every write, so the plain minimum write pulse is enough. After each read the controller keeps the bus idle for the turnaround count, so the RAM and the controller never drive the bus in the same cycle.

Top module: `sram_ctrl`

## Requirements
- R1: After a synchronous reset, chip select, write enable and output enable are all high (1), the data bus is released, `req_ready` is 1 and `rsp_valid` is 0.
- R2: An accepted write stores `req_wdata` at `req_addr` in the RAM. Write enable is low only while chip select is low, and it falls at least one cycle after chip select falls.
- R3: Output enable is high in every cycle where write enable is low. The controller drives the data bus only while output enable is high.
- R4: The address bus does not change in any cycle where write enable is low, nor in the cycle just after write enable rises.
- R5: Each write pulse (write enable low together with chip select low) lasts exactly WR_CYC cycles. WR_CYC is the write-pulse time rounded up to whole clock periods (4 at the defaults).
- R6: An accepted read holds chip select and output enable low for RD_CYC cycles (5 at the defaults). It then raises `rsp_valid` for exactly one cycle, RD_CYC+1 cycles after the accepting clock edge, with `rsp_rdata` equal to the byte last written at that address.
- R7: After a read, chip select and output enable stay high for TA_CYC cycles (2 at the defaults) before the next request can be accepted. Write enable never falls less than TA_CYC cycles after output enable rises.
- R8: `req_ready` is high only when the controller is idle. It goes low in the cycle after a request is accepted.
- R9: A write occupies the controller for WR_CYC+2 cycles after the accepting edge: one setup cycle, the pulse and one hold cycle. `req_ready` returns in the next cycle, and a write produces no `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | One-cycle pulse marking returned read data |
| rsp_rdata | output | 8 | Returned read byte |
| sram_addr | output | 15 | RAM address bus |
| sram_cs_n | output | 1 | RAM chip select, active low |
| sram_we_n | output | 1 | RAM write enable, active low |
| sram_oe_n | output | 1 | RAM output enable, active low |
| sram_dq | inout | 8 | Shared RAM data bus |

## Verification
Two functions can land close together: the read response pulse with the start of the bus turnaround, and a write request that arrives as soon as that turnaround ends. The bench sends a write immediately after a read, at the same address and at other addresses. It also runs a long random mix of back-to-back reads and writes in a narrow address window. A behavioural RAM model watches the pins at each falling clock edge. It counts any address change around a write pulse, any write pulse with output enable low, and any write enable fall that comes too soon after output enable rises. Every returned byte is compared with a reference array in the bench.

// File: rtl/sram_ctrl_pkg.sv
// Shared types and helpers for the asynchronous RAM controller.
// Assumes all times are given in picoseconds and are non-negative.
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_TURN,
        ST_WSET,
        ST_WPULSE,
        ST_WHOLD
    } seq_state_e;

    // Whole clock cycles needed to cover a time, rounded up, at least one.
    function automatic int unsigned cycles_for(input int unsigned t_ps,
                                               input int unsigned clk_ps);
        int unsigned c;
        c = (t_ps + clk_ps - 1) / clk_ps;
        return (c == 0) ? 1 : c;
    endfunction

endpackage

// File: rtl/sram_seq.sv
// Strobe sequencer: walks one host request through the RAM cycle and
// produces registered, glitch-free strobes and address.
// Assumes RD_CYC, WR_CYC and TA_CYC are all at least 1.
module sram_seq
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int RD_CYC = 5,
    parameter int WR_CYC = 4,
    parameter int TA_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              accept,
    output logic              cap_en,
    output logic              drive_en,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              cs_n,
    output logic              we_n,
    output logic              oe_n
);

    localparam int MAX_A = (RD_CYC > WR_CYC) ? RD_CYC : WR_CYC;
    localparam int MAXC  = (MAX_A > TA_CYC) ? MAX_A : TA_CYC;
    localparam int CNT_W = $clog2(MAXC + 1);
    localparam int RUN_W = $clog2(MAXC + 3) + 1;

    seq_state_e       state, nxt;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;
    logic             last;

    // Cycle budget of the current timed state.
    always_comb begin
        unique case (state)
            ST_RD:     limit = CNT_W'(RD_CYC - 1);
            ST_WPULSE: limit = CNT_W'(WR_CYC - 1);
            ST_TURN:   limit = CNT_W'(TA_CYC - 1);
            default:   limit = '0;
        endcase
    end

    assign last      = (cnt == limit);
    assign req_ready = (state == ST_IDLE);
    assign accept    = req_ready && req_valid;
    assign cap_en    = (state == ST_RD) && last;

    // Next-state selection for the request sequence.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (req_valid) nxt = req_write ? ST_WSET : ST_RD;
            ST_RD:     if (last) nxt = ST_TURN;
            ST_TURN:   if (last) nxt = ST_IDLE;
            ST_WSET:   nxt = ST_WPULSE;
            ST_WPULSE: if (last) nxt = ST_WHOLD;
            ST_WHOLD:  nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // State, counter, strobe and address registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            cs_n      <= 1'b1;
            we_n      <= 1'b1;
            oe_n      <= 1'b1;
            drive_en  <= 1'b0;
            sram_addr <= '0;
        end else begin
            state    <= nxt;
            cnt      <= (nxt != state || state == ST_IDLE) ? '0 : cnt + 1'b1;
            cs_n     <= (nxt == ST_IDLE) || (nxt == ST_TURN);
            we_n     <= (nxt != ST_WPULSE);
            oe_n     <= (nxt != ST_RD);
            drive_en <= (nxt == ST_WSET) || (nxt == ST_WPULSE) || (nxt == ST_WHOLD);
            if (accept) sram_addr <= req_addr;
        end
    end

    // Checker counters: length of the current write-enable-low run and of
    // the current output-enable-high run, both saturating.
    logic [RUN_W-1:0] we_low_run;
    logic [RUN_W-1:0] oe_high_run;

    // Track pin run lengths for the timing assertions below.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_low_run  <= '0;
            oe_high_run <= RUN_W'(MAXC + 2);
        end else begin
            we_low_run  <= !we_n ? ((we_low_run == RUN_W'(MAXC + 2)) ? we_low_run
                                    : we_low_run + 1'b1) : '0;
            oe_high_run <= oe_n ? ((oe_high_run == RUN_W'(MAXC + 2)) ? oe_high_run
                                   : oe_high_run + 1'b1) : '0;
        end
    end

    a_r2_we_inside_cs: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> !cs_n);
    a_r2_cs_before_we: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(we_n) |-> $past(!cs_n));
    a_r3_oe_high_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> oe_n);
    a_r4_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n || $past(!we_n)) |-> $stable(sram_addr));
    a_r5_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> (we_low_run == RUN_W'(WR_CYC)));
    a_r7_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(we_n) |-> (oe_high_run >= RUN_W'(TA_CYC)));
    a_r8_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (cs_n && we_n && oe_n));

endmodule

// File: rtl/sram_dq_io.sv
// Data-path half: holds the write byte, enables the bus driver and
// captures read data into a register with a one-cycle valid pulse.
// Assumes the sequencer raises drive_en only while output enable is high.
module sram_dq_io #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              drive_en,
    input  logic              cap_en,
    input  logic              oe_n,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);

    // Latch the write byte at acceptance so the bus stays steady.
    always_ff @(posedge clk) begin
        if (!rst_n) dq_out <= '0;
        else if (accept) dq_out <= req_wdata;
    end

    assign dq_oe = drive_en;

    // Capture the RAM byte at the end of the access window and flag it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= cap_en;
            if (cap_en) rsp_rdata <= dq_in;
        end
    end

    a_r3_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> oe_n);
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    a_r6_capture_in_read: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |-> (!oe_n && !dq_oe));

endmodule

// File: rtl/sram_ctrl.sv
// Top of the asynchronous static RAM controller. Converts speed-grade
// times into cycle counts, joins sequencer and data path, and resolves
// the tristate data bus. Assumes one RAM device on the bus.
module sram_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W   = 15,
    parameter int DATA_W   = 8,
    parameter int CLK_PS   = 4000,
    parameter int T_RD_PS  = 20000,
    parameter int T_WP_PS  = 15000,
    parameter int T_TA_PS  = 5000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_cs_n,
    output logic              sram_we_n,
    output logic              sram_oe_n,
    inout  wire  [DATA_W-1:0] sram_dq
);

    localparam int RD_CYC = int'(cycles_for(T_RD_PS, CLK_PS));
    localparam int WR_CYC = int'(cycles_for(T_WP_PS, CLK_PS));
    localparam int TA_CYC = int'(cycles_for(T_TA_PS, CLK_PS));

    logic              accept;
    logic              cap_en;
    logic              drive_en;
    logic              dq_oe;
    logic [DATA_W-1:0] dq_out;

    sram_seq #(
        .ADDR_W (ADDR_W),
        .RD_CYC (RD_CYC),
        .WR_CYC (WR_CYC),
        .TA_CYC (TA_CYC)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_ready (req_ready),
        .accept    (accept),
        .cap_en    (cap_en),
        .drive_en  (drive_en),
        .sram_addr (sram_addr),
        .cs_n      (sram_cs_n),
        .we_n      (sram_we_n),
        .oe_n      (sram_oe_n)
    );

    sram_dq_io #(
        .DATA_W (DATA_W)
    ) u_io (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .req_wdata (req_wdata),
        .drive_en  (drive_en),
        .cap_en    (cap_en),
        .oe_n      (sram_oe_n),
        .dq_in     (sram_dq),
        .dq_out    (dq_out),
        .dq_oe     (dq_oe),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    assign sram_dq = dq_oe ? dq_out : {DATA_W{1'bz}};

    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $past(!rst_n) |-> (sram_cs_n && sram_we_n && sram_oe_n && !rsp_valid));

endmodule

// File: tb/sram_ctrl_test.sv
// Bench: behavioural RAM on the pins, directed corner cases and a seeded
// random mix, all checked against a reference array in the bench.
module sram_ctrl_test;

    localparam int CLK_PS = 4000;
    localparam int RD = (20000 + CLK_PS - 1) / CLK_PS;
    localparam int WR = (15000 + CLK_PS - 1) / CLK_PS;
    localparam int TA = (5000 + CLK_PS - 1) / CLK_PS;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [14:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready;
    logic        rsp_valid;
    logic [7:0]  rsp_rdata;
    logic [14:0] sram_addr;
    logic        sram_cs_n, sram_we_n, sram_oe_n;
    wire  [7:0]  sram_dq;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sram_ctrl uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .sram_addr(sram_addr),
        .sram_cs_n(sram_cs_n), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
        .sram_dq(sram_dq)
    );

    // ---------------- behavioural RAM model ----------------
    logic [7:0]  mdl_mem [int];
    logic [7:0]  ref_mem [int];
    logic [7:0]  mdl_byte = '0;
    logic        mdl_drive;
    logic        prev_ovl = 1'b0, prev_we_n = 1'b1;
    logic [14:0] prev_addr = '0;
    logic [7:0]  wdat = '0;
    int          pulse = 0, oe_hi = 100;
    int          addr_viol = 0, oe_viol = 0, ta_viol = 0, pulse_err = 0;

    function automatic logic [7:0] init_val(input logic [14:0] a);
        return a[7:0] ^ {1'b0, a[14:8]};
    endfunction

    assign mdl_drive = !sram_cs_n && sram_we_n && !sram_oe_n;
    assign sram_dq   = mdl_drive ? mdl_byte : 8'bz;

    // Pin watcher and storage, sampled away from the active edge.
    always @(negedge clk) begin
        logic ovl;
        if (rst_n) begin
            ovl = !sram_cs_n && !sram_we_n;
            mdl_byte = mdl_mem.exists(int'(sram_addr)) ? mdl_mem[int'(sram_addr)]
                                                       : init_val(sram_addr);
            if ((ovl || prev_ovl) && sram_addr != prev_addr) addr_viol++;
            if (!sram_we_n && !sram_oe_n) oe_viol++;
            if (!sram_we_n && prev_we_n && oe_hi < TA) ta_viol++;
            if (ovl) begin
                pulse++;
                wdat = sram_dq;
            end
            if (!ovl && prev_ovl) begin
                mdl_mem[int'(prev_addr)] = wdat;
                if (pulse != WR) pulse_err++;
                pulse = 0;
            end
            oe_hi = sram_oe_n ? ((oe_hi < 100) ? oe_hi + 1 : oe_hi) : 0;
            prev_ovl  = ovl;
            prev_we_n = sram_we_n;
            prev_addr = sram_addr;
        end
    end

    // ---------------- checking helpers ----------------
    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] expect_byte(input logic [14:0] a);
        return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : init_val(a);
    endfunction

    // One host request; called at a falling edge, returns at one with ready high.
    task automatic run_op(input bit wr, input logic [14:0] a, input logic [7:0] d);
        int n, rsp_n, rsp_cnt;
        logic [7:0] q;
        check(req_ready == 1'b1, "R8 idle before request", int'(req_ready), 1);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R8 busy after accept", int'(req_ready), 0);
        n = 1; rsp_n = 0; rsp_cnt = 0; q = '0;
        while (!req_ready && n < 64) begin
            if (rsp_valid) begin
                rsp_cnt++;
                rsp_n = n;
                q = rsp_rdata;
            end
            @(negedge clk);
            n++;
        end
        if (wr) begin
            check(n == WR + 3, "R9 write occupancy", n, WR + 3);
            check(rsp_cnt == 0, "R9 no response on write", rsp_cnt, 0);
            ref_mem[int'(a)] = d;
        end else begin
            check(n == RD + TA + 1, "R7 read plus turnaround", n, RD + TA + 1);
            check(rsp_cnt == 1 && rsp_n == RD + 1, "R6 response timing", rsp_n, RD + 1);
            check(q == expect_byte(a), "R6 R2 read data", int'(q), int'(expect_byte(a)));
        end
    endtask

    // ---------------- stimulus ----------------
    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: quiet state straight after reset
        check(sram_cs_n && sram_we_n && sram_oe_n, "R1 strobes high",
              int'({sram_cs_n, sram_we_n, sram_oe_n}), 7);
        check(req_ready && !rsp_valid, "R1 ready and no response",
              int'({req_ready, rsp_valid}), 2);

        // Directed corners: ends of the address space, overwrite, unwritten,
        // write straight after read.
        run_op(1'b1, 15'h0000, 8'h5A);
        run_op(1'b0, 15'h0000, 8'h00);
        run_op(1'b1, 15'h7FFF, 8'hC3);
        run_op(1'b0, 15'h7FFF, 8'h00);
        run_op(1'b0, 15'h1234, 8'h00);
        run_op(1'b1, 15'h1234, 8'hFF);
        run_op(1'b1, 15'h1234, 8'h01);
        run_op(1'b0, 15'h1234, 8'h00);
        run_op(1'b1, 15'h0001, 8'h80);
        run_op(1'b0, 15'h0001, 8'h00);

        // Seeded random mix in a narrow window so addresses repeat.
        for (int i = 0; i < 400; i++) begin
            logic [14:0] a;
            a = {($urandom % 4 == 0) ? 9'h1FF : 9'($urandom % 3), 6'($urandom)};
            run_op(1'($urandom), a, 8'($urandom));
        end

        check(addr_viol == 0, "R4 address steady around write", addr_viol, 0);
        check(oe_viol == 0, "R3 output enable high in write", oe_viol, 0);
        check(ta_viol == 0, "R7 turnaround before write", ta_viol, 0);
        check(pulse_err == 0, "R5 write pulse length", pulse_err, 0);

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
        end
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
        end
        $finish;
    end

endmodule